// File: doc/BRIEF.md
# Configuration-Bit Programming Controller

This block lets software set three non-volatile configuration bits through a small register window. Two of the bits are security bits, labelled SEC0 and SEC1. The third enables clock doubling. Programming a bit takes three writes: an address key, a data key, and then a command byte. The block compares the key pair and the command code against a fixed table. When the combination is valid, it starts a timed programming operation and raises a busy flag until the operation ends.

On completion the block either clears the busy flag so that software can poll for it, or it also issues a one-cycle pulse on an internal interrupt line. Bit 7 of the command byte selects between these two endings. A programming operation can only set a stored bit, never clear it. The stored bits are held across a reset. The live configuration outputs copy the stored bits only while reset is asserted, so a newly programmed bit takes effect after the next reset.

Top module: `cfgbit_prog_ctrl`

## Requirements
- R1: During reset and in the cycle after it, the block reads idle: `busy` (read address 1, bit 2) is 0, `irq` is 0, and the enable bit (read address 0, bit 6) is 0. Each live output equals its stored bit: SEC0, SEC1 and clock double. `clocks_per_cycle` reads 12 when clock double is off and 6 when it is on.
- R2: A write to address 0 sets the programming enable to `wr_data[6]`. While the enable is 0, a command write to address 1 starts nothing and changes no stored bit.
- R3: Command code 0x09 (command bits 6:0) with address key 0xAA (address 2) and data key 0xAA (address 3) programs SEC1.
- R4: Command code 0x09 with address key 0x5A and data key 0xAA programs SEC0.
- R5: Command code 0x08 with address key 0x55 and data key 0xAA programs clock double. After the next reset, `clk_x2_live` is 1 and `clocks_per_cycle` is 6.
- R6: An accepted command holds busy at 1 for exactly PROG_CYCLES cycles, starting in the cycle after the command write. The programmed bit is stored when busy returns to 0.
- R7: With command bit 7 set, `irq` is high for exactly one cycle, the first cycle in which busy reads 0 again. With bit 7 clear, `irq` stays 0.
- R8: The live outputs do not change outside reset, including after a programming operation completes.
- R9: Programming a bit that is already set leaves it set. No command can clear a stored bit.
- R10: A command whose code and key pair do not form one of the three valid combinations starts no operation and changes no stored bit.
- R11: A command written while busy is 1 is ignored. It neither lengthens the current operation nor programs its own bit.
- R12: Stored bits survive reset, and the live outputs reload from them on every reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 command, 2 address key, 3 data key |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 enable, 1 status, 2 address key, 3 data key |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Completion interrupt pulse |
| sec0_live | output | 1 | Live SEC0 bit |
| sec1_live | output | 1 | Live SEC1 bit |
| clk_x2_live | output | 1 | Live clock-double enable |
| clocks_per_cycle | output | 4 | Clocks per machine cycle: 12 or 6 |

## Verification
Each result is due at a fixed cycle. Busy reads 1 one clock after the command write edge and stays high for PROG_CYCLES samples. The drop of busy and the `irq` pulse are due at the next sample, and `irq` is low again one sample later. Register writes and reads of the enable bit take effect one edge after the write. The bench drives inputs and samples outputs on the falling edge, and it counts samples from the command write. Stored bits are only observable after a reset, so the bench checks its expected stored value against the live outputs immediately after each reset, and checks that the live outputs are unchanged after every command.

// File: rtl/cfgbit_prog_ctrl.sv
module cfgbit_prog_ctrl #(
  parameter int PROG_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       sec0_live,
  output logic       sec1_live,
  output logic       clk_x2_live,
  output logic [3:0] clocks_per_cycle
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] A_CFG = 2'd0, A_CMD = 2'd1, A_AKEY = 2'd2, A_DKEY = 2'd3;

  logic          iap_en, busy, irq_mode;
  logic [7:0]    akey, dkey;
  logic [2:0]    tgt, sel, live;
  logic [2:0]    nv = 3'b000;
  logic [CW-1:0] cnt;
  logic          accept, done;

  always_comb begin
    sel = 3'b000;
    if (dkey == 8'hAA) begin
      if (wr_data[6:0] == 7'h09 && akey == 8'hAA) sel = 3'b010;
      else if (wr_data[6:0] == 7'h09 && akey == 8'h5A) sel = 3'b001;
      else if (wr_data[6:0] == 7'h08 && akey == 8'h55) sel = 3'b100;
    end
  end

  assign accept = wr_en && wr_addr == A_CMD && iap_en && !busy && |sel;
  assign done   = busy && cnt == CW'(1);

  always_ff @(posedge clk)
    if (rst_n && done) nv <= nv | tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iap_en   <= 1'b0;
      akey     <= '0;
      dkey     <= '0;
      busy     <= 1'b0;
      irq_mode <= 1'b0;
      irq      <= 1'b0;
      tgt      <= '0;
      cnt      <= '0;
      live     <= nv;
    end else begin
      irq <= done && irq_mode;
      if (wr_en && wr_addr == A_CFG)  iap_en <= wr_data[6];
      if (wr_en && wr_addr == A_AKEY) akey <= wr_data;
      if (wr_en && wr_addr == A_DKEY) dkey <= wr_data;
      if (accept) begin
        busy     <= 1'b1;
        cnt      <= CW'(PROG_CYCLES);
        tgt      <= sel;
        irq_mode <= wr_data[7];
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (done) busy <= 1'b0;
      end
    end
  end

  always_comb
    case (rd_addr)
      A_CFG:   rd_data = {1'b0, iap_en, 6'b0};
      A_CMD:   rd_data = {5'b0, busy, 2'b0};
      A_AKEY:  rd_data = akey;
      default: rd_data = dkey;
    endcase

  assign sec0_live        = live[0];
  assign sec1_live        = live[1];
  assign clk_x2_live      = live[2];
  assign clocks_per_cycle = live[2] ? 4'd6 : 4'd12;
endmodule

// File: rtl/cfgbit_prog_ctrl_chk.sv
module cfgbit_prog_ctrl_chk #(
  parameter int PROG_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       busy,
  input logic       irq,
  input logic [2:0] nv,
  input logic [2:0] live
);
  localparam int RW = $clog2(PROG_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk)
    if (!rst_n || !busy) run <= '0;
    else run <= run + RW'(1);

  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RW'(PROG_CYCLES));
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(PROG_CYCLES));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_addr == 2'd1));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && $past(busy));
  // R9
  nv_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nv) & ~nv) == 3'b000);
  // R8
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(live));
endmodule

bind cfgbit_prog_ctrl cfgbit_prog_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy), .irq(irq), .nv(nv), .live(live)
);

// File: tb/sim_cfgbit_prog_ctrl.sv
module sim_cfgbit_prog_ctrl;
  localparam int P = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, irq, s0, s1, x2;
  logic [1:0] wr_addr = 0, rd_addr = 1;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] cpc;
  int checks = 0, errors = 0;
  logic [2:0] exp_nv = 0, exp_live = 0;
  bit exp_iap = 0;

  always #4 clk = ~clk;

  cfgbit_prog_ctrl #(.PROG_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .sec0_live(s0),
    .sec1_live(s1), .clk_x2_live(x2), .clocks_per_cycle(cpc));

  function automatic logic [2:0] dec(logic [7:0] ak, logic [7:0] dk, logic [7:0] cmd);
    if (dk != 8'hAA) return 3'b000;
    if (cmd[6:0] == 7'h09 && ak == 8'hAA) return 3'b010;
    if (cmd[6:0] == 7'h09 && ak == 8'h5A) return 3'b001;
    if (cmd[6:0] == 7'h08 && ak == 8'h55) return 3'b100;
    return 3'b000;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_live(string req);
    chk(req, {x2, s1, s0}, exp_live);
    chk(req, cpc, exp_live[2] ? 6 : 12);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_live = exp_nv; exp_iap = 0;
    // R1 R12: idle state and live outputs reloaded from stored bits
    chk("R1", rd_data[2], 0);
    chk("R1", irq, 0);
    rd_addr = 0; #1;
    chk("R1", rd_data[6], 0);
    rd_addr = 1;
    chk_live("R12");
  endtask

  task automatic set_iap(bit en);
    wr(0, {1'b0, en, 6'b0});
    exp_iap = en;
  endtask

  task automatic do_cmd(logic [7:0] ak, logic [7:0] dk, logic [7:0] cmd, bit interfere);
    logic [2:0] s;
    s = exp_iap ? dec(ak, dk, cmd) : 3'b000;
    wr(2, ak); wr(3, dk); wr(1, cmd);
    if (s != 0) begin
      for (int j = 0; j < P; j++) begin
        chk("R6", rd_data[2], 1);
        chk("R7", irq, 0);
        if (interfere && j == 2) begin
          wr_en = 1; wr_addr = 1; wr_data = 8'h08;
          @(negedge clk);
          wr_en = 0;
        end else @(negedge clk);
      end
      // R6 R11: busy ends on time; R7 irq pulse per bit 7
      chk("R6", rd_data[2], 0);
      chk("R7", irq, cmd[7]);
      exp_nv |= s;
      @(negedge clk);
      chk("R7", irq, 0);
    end else begin
      for (int j = 0; j < 3; j++) begin
        // R2 R10: rejected command starts nothing
        chk("R10", rd_data[2], 0);
        chk("R10", irq, 0);
        @(negedge clk);
      end
    end
    // R8: live outputs untouched until reset
    chk_live("R8");
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    chk("R1", {x2, s1, s0}, 0);
    // R2: disabled path
    do_cmd(8'hAA, 8'hAA, 8'h89, 0);
    do_reset();
    chk("R2", s1, 0);
    // R3 with interrupt ending
    set_iap(1);
    rd_addr = 0; #1; chk("R2", rd_data[6], 1); rd_addr = 1;
    do_cmd(8'hAA, 8'hAA, 8'h89, 0);
    do_reset();
    chk("R3", s1, 1);
    // R4 polling, with a command written during busy (R11)
    set_iap(1);
    do_cmd(8'h5A, 8'hAA, 8'h09, 1);
    do_reset();
    chk("R4", s0, 1);
    chk("R11", x2, 0);
    // R10: wrong key pairs
    set_iap(1);
    do_cmd(8'h55, 8'hAA, 8'h09, 0);
    do_cmd(8'hAA, 8'h55, 8'h08, 0);
    do_reset();
    chk("R10", x2, 0);
    // R5
    set_iap(1);
    do_cmd(8'h55, 8'hAA, 8'h88, 0);
    do_reset();
    chk("R5", x2, 1);
    chk("R5", cpc, 6);
    // R9: reprogram an already set bit
    set_iap(1);
    do_cmd(8'hAA, 8'hAA, 8'h09, 0);
    do_reset();
    chk("R9", {x2, s1, s0}, 3'b111);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] ak, dk, cmd;
      int r;
      r = $urandom_range(0, 3);
      ak = (r == 0) ? 8'hAA : (r == 1) ? 8'h5A : (r == 2) ? 8'h55 : 8'($urandom);
      dk = ($urandom_range(0, 3) != 0) ? 8'hAA : 8'($urandom);
      cmd = {1'($urandom), ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h08 | 7'($urandom_range(0, 1))};
      set_iap($urandom_range(0, 4) != 0);
      do_cmd(ak, dk, cmd, $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 5) == 0) do_reset();
    end
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule